// File: doc/BRIEF.md
# Look-Ahead Parallel Decision Selector for a Loop-Unrolled DFE

This block is the digital end of a decision feedback equalizer whose first tap is unrolled. It runs on a clock at one quarter of the line rate. In every clock it takes a word of four symbols. Each symbol comes as two already-sliced bits: one sliced as if the bit before it was 0, which is the additive correction, and one sliced as if that bit was 1, which is the subtractive correction. The block returns the four resolved bits together with a valid flag.

A plain serial implementation would place one 2:1 multiplexer per bit in the feedback loop. This block does not. It groups neighbouring symbols into pairs. For each pair it computes both two-bit outcomes ahead of time, one for each possible value of the bit that precedes the pair. Those outcomes are held in a register stage. In the next clock, one selector per pair picks the right outcome. The loop through a word is therefore two selector stages long, not four. The last bit of each resolved word is kept and used as the history for the first bit of the next valid word.

Top module: `lad_dfe_selector`

## Requirements
- R1: While reset is active, and after it is released, out_valid is 0. The stored history bit is 0, so the first valid word after reset resolves symbol 0 with the candidate for a prior bit of 0.
- R2: In each valid output word, every bit equals the candidate of its symbol chosen by the bit decided just before it. A value of 0 selects cand0 and a value of 1 selects cand1.
- R3: Bit 0 of a valid word is chosen by bit 3 of the most recent earlier valid word.
- R4: A word presented with in_valid high appears on bits with out_valid high exactly two clock cycles later.
- R5: A cycle with in_valid low yields out_valid low two cycles later. Its candidates have no effect on the history bit or on any later output.
- R6: Index 0 is the oldest symbol on cand0, cand1 and bits, and index 3 is the newest. For example, with history 0, cand0=4'b1111 and cand1=4'b0000 give bits=4'b0101.
- R7: Valid words may arrive in every cycle. Each one is resolved with the correct history, at a throughput of one word per clock.
- R8: A reset asserted in the middle of a stream discards the words in flight and returns the history bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cand0 | input | 4 | Per-symbol candidate for a prior bit of 0, index 0 oldest |
| cand1 | input | 4 | Per-symbol candidate for a prior bit of 1, index 0 oldest |
| in_valid | input | 1 | Candidates in this cycle form a word |
| bits | output | 4 | Resolved bits, index 0 oldest |
| out_valid | output | 1 | bits holds a resolved word |

## Verification
The hardest case to reach is history crossing a word boundary, because the first selector of one word depends on the last bit of another word. This must hold when the words are back to back, when invalid cycles full of random candidates sit between them, and when a reset falls between them. The stimulus therefore mixes unbroken random streams, streams with gaps of random length, and a reset in mid-stream. Each of these is compared against a serial model that only ever looks at the single previous bit.

// File: rtl/lad_pkg.sv
package lad_pkg;
  // Both resolutions of a symbol pair; bit 0 is the earlier symbol.
  typedef struct packed {
    logic [1:0] if_one;   // prior bit was 1
    logic [1:0] if_zero;  // prior bit was 0
  } pair_opts_t;
endpackage

// File: rtl/lad_rst_sync.sv
module lad_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/lad_pair_lookahead.sv
module lad_pair_lookahead
  import lad_pkg::*;
(
  input  logic       c0_early,
  input  logic       c1_early,
  input  logic       c0_late,
  input  logic       c1_late,
  output pair_opts_t opts
);
  logic early_if_zero, early_if_one;

  always_comb begin
    early_if_zero = c0_early;
    early_if_one  = c1_early;
    opts.if_zero  = {(early_if_zero ? c1_late : c0_late), early_if_zero};
    opts.if_one   = {(early_if_one  ? c1_late : c0_late), early_if_one};
  end
endmodule

// File: rtl/lad_pair_chain.sv
module lad_pair_chain
  import lad_pkg::*;
#(
  parameter int PAIRS = 2
) (
  input  logic                     prev_bit,
  input  pair_opts_t [PAIRS-1:0]   opts,
  output logic [2*PAIRS-1:0]       word
);
  logic [PAIRS-1:0] pair_prev;

  for (genvar p = 0; p < PAIRS; p++) begin : g_sel
    if (p == 0) begin : g_head
      assign pair_prev[p] = prev_bit;
    end else begin : g_link
      assign pair_prev[p] = word[2*p-1];
    end
    assign word[2*p +: 2] = pair_prev[p] ? opts[p].if_one : opts[p].if_zero;
  end
endmodule

// File: rtl/lad_dfe_selector.sv
module lad_dfe_selector
  import lad_pkg::*;
#(
  parameter int WORD_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WORD_BITS-1:0] cand0,
  input  logic [WORD_BITS-1:0] cand1,
  input  logic                 in_valid,
  output logic [WORD_BITS-1:0] bits,
  output logic                 out_valid
);
  localparam int PAIRS = WORD_BITS / 2;

  initial begin
    assert (WORD_BITS % 2 == 0 && WORD_BITS >= 2)
      else $error("WORD_BITS must be even and at least 2");
  end

  logic rst_s_n;
  lad_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  // Look-ahead precompute, one independent unit per pair
  pair_opts_t [PAIRS-1:0] pre_opts;
  for (genvar p = 0; p < PAIRS; p++) begin : g_pre
    lad_pair_lookahead u_la (
      .c0_early(cand0[2*p]),   .c1_early(cand1[2*p]),
      .c0_late (cand0[2*p+1]), .c1_late (cand1[2*p+1]),
      .opts    (pre_opts[p])
    );
  end

  // Look-ahead hold stage
  pair_opts_t [PAIRS-1:0] stg_opts_q, stg_opts_d;
  logic                   stg_vld_q, stg_vld_d;

  always_comb begin
    stg_vld_d  = in_valid;
    stg_opts_d = in_valid ? pre_opts : stg_opts_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      stg_vld_q  <= 1'b0;
      stg_opts_q <= '0;
    end else begin
      stg_vld_q  <= stg_vld_d;
      stg_opts_q <= stg_opts_d;
    end
  end

  // Selection chain closed through the history bit
  logic                 fb_q, fb_d;
  logic [WORD_BITS-1:0] sel_word;

  lad_pair_chain #(.PAIRS(PAIRS)) u_chain (
    .prev_bit(fb_q),
    .opts    (stg_opts_q),
    .word    (sel_word)
  );

  logic [WORD_BITS-1:0] bits_q, bits_d;
  logic                 ov_q, ov_d;

  always_comb begin
    ov_d   = stg_vld_q;
    bits_d = stg_vld_q ? sel_word : bits_q;
    fb_d   = stg_vld_q ? sel_word[WORD_BITS-1] : fb_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ov_q   <= 1'b0;
      bits_q <= '0;
      fb_q   <= 1'b0;
    end else begin
      ov_q   <= ov_d;
      bits_q <= bits_d;
      fb_q   <= fb_d;
    end
  end

  assign bits      = bits_q;
  assign out_valid = ov_q;

  // R4: fixed two-cycle latency for valid words
  a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_valid |-> ##2 out_valid);
  // R5: idle inputs yield idle outputs
  a_r5_idle_no_output: assert property (@(posedge clk) disable iff (!rst_s_n)
    !in_valid |-> ##2 !out_valid);
  // R5: history untouched when the hold stage carries no word
  a_r5_history_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    !stg_vld_q |=> $stable(fb_q));
  // R3: history always equals the newest bit of the last output word
  a_r3_history_tracks: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid |-> (fb_q == bits[WORD_BITS-1]));
  // R1: nothing leaves the block in the first cycle after reset release
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(rst_s_n) |-> !out_valid);
endmodule

// File: tb/lad_dfe_selector_test.sv
module lad_dfe_selector_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] cand0, cand1;
  logic       in_valid;
  logic [3:0] bits;
  logic       out_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic       model_fb;
  logic       ev1, ev2;
  logic [3:0] ew1, ew2;
  string      et1, et2;

  always #5 clk = ~clk;

  lad_dfe_selector uut (
    .clk(clk), .rst_n(rst_n), .cand0(cand0), .cand1(cand1),
    .in_valid(in_valid), .bits(bits), .out_valid(out_valid)
  );

  function automatic logic [3:0] serial_ref(input logic [3:0] c0, input logic [3:0] c1,
                                            input logic prev);
    logic [3:0] w;
    logic p;
    p = prev;
    for (int i = 0; i < 4; i++) begin
      w[i] = p ? c1[i] : c0[i];
      p = w[i];
    end
    return w;
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: check the word driven two steps ago, then drive a new one.
  task automatic step(input logic [3:0] c0, input logic [3:0] c1, input logic v,
                      input string tag);
    logic [3:0] w;
    @(negedge clk);
    check({et2, " R4 out_valid"}, {3'b0, out_valid}, {3'b0, ev2});
    if (ev2) check(et2, bits, ew2);
    w = serial_ref(c0, c1, model_fb);
    ev2 = ev1; ew2 = ew1; et2 = et1;
    ev1 = v;   ew1 = w;   et1 = tag;
    if (v) model_fb = w[3];
    cand0 = c0; cand1 = c1; in_valid = v;
  endtask

  task automatic flush_pipe();
    ev1 = 0; ev2 = 0; ew1 = '0; ew2 = '0; et1 = "R5"; et2 = "R5";
    model_fb = 1'b0;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; in_valid = 1'b0; cand0 = '0; cand1 = '0;
    flush_pipe();
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {3'b0, out_valid}, 4'b0);
    rst_n = 1'b1;
    repeat (4) step('0, '0, 1'b0, "R1 idle after release");
    // first word: symbol 0 must use the candidate for prior 0
    step(4'b0000, 4'b1111, 1'b1, "R1 first word prior 0");
    repeat (2) step('0, '0, 1'b0, "R5");
  endtask

  task automatic t_known_order();
    // history is 0 here (previous word was all zeros)
    step(4'b1111, 4'b0000, 1'b1, "R6 ordering");
    repeat (2) step('0, '0, 1'b0, "R5");
    check("R6 literal word", bits, 4'b0101);
    check("R3 history from bit 3", bits, {1'b0, bits[2:0]});
  endtask

  task automatic t_stream();
    for (int i = 0; i < 400; i++)
      step(4'($urandom), 4'($urandom), 1'b1, "R2 R7 stream");
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 200; i++) begin
      step(4'($urandom), 4'($urandom), 1'b1, "R3 across gap");
      for (int g = 0; g < int'($urandom_range(0, 3)); g++)
        step(4'($urandom), 4'($urandom), 1'b0, "R5 gap ignored");
    end
  endtask

  task automatic t_corner_patterns();
    // cand0 all ones, cand1 all zeros: bits alternate, history flips every bit
    for (int i = 0; i < 8; i++) step(4'b1111, 4'b0000, 1'b1, "R2 alternating");
    // identical candidates: history irrelevant
    for (int i = 0; i < 8; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(r, r, 1'b1, "R2 equal candidates");
    end
    // cand0 zeros, cand1 ones: history latches forever
    for (int i = 0; i < 8; i++) step(4'b0000, 4'b1111, 1'b1, "R3 sticky history");
    repeat (2) step('0, '0, 1'b0, "R5");
  endtask

  task automatic t_mid_reset();
    // leave history at 1, with words in flight
    step(4'b0000, 4'b1111, 1'b1, "R8 preload");
    step(4'b1000, 4'b1000, 1'b1, "R8 preload");
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    flush_pipe();
    #1;
    check("R8 out_valid cleared", {3'b0, out_valid}, 4'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step('0, '0, 1'b0, "R8 idle after reset");
    step(4'b0000, 4'b1111, 1'b1, "R8 history back to 0");
    repeat (2) step('0, '0, 1'b0, "R5");
  endtask

  initial begin
    t_reset_state();
    t_known_order();
    t_stream();
    t_gaps();
    t_corner_patterns();
    t_mid_reset();
    repeat (2) step('0, '0, 1'b0, "R5 drain");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule